// File: doc/BRIEF.md
# Raster-Time Shape Overlay Generator

This block paints simple vector shapes over a video raster with no frame store. A video timing source presents one pixel coordinate per clock, together with a strobe that marks it as visible. For that coordinate the block evaluates each primitive's defining equation: a circle, a bounded diagonal line and a rectangle outline. It reports whether the pixel should be drawn and which shape claimed it. Horizontal and vertical lines are rectangle outlines whose two x bounds, or two y bounds, are equal.

Shape parameters arrive on plain input ports, but the evaluators never use them directly. A working copy is taken only in a cycle where the frame-start strobe is high, so a shape changed by software in the middle of a frame never tears. The arithmetic is signed and spread over three register stages. Every pixel result appears exactly three clocks after its coordinate, at a rate of one per clock.

Top module: `shape_overlay`

## Requirements
- R1: While reset is held, and after it is released, draw_valid, draw and draw_sel are 0. Until the first frame start every shape is disabled, so valid pixels give draw=0.
- R2: A coordinate presented with pix_valid=1 at a rising edge yields its result at the third rising edge after it, with draw_valid=1, and one result can be produced on every clock. draw_valid repeats pix_valid delayed by three clocks.
- R3: A pixel lies on the circle when |(x-cx)^2 + (y-cy)^2 - r^2| <= r*ctol, evaluated on signed integers.
- R4: A pixel lies on the line when |kx*x + ky*y - c| <= ltol, kx, ky and c being two's complement, and also xlo < x < xhi with both bounds strict.
- R5: A pixel lies on the rectangle outline when x equals xl or xr and yt <= y <= yb, or when y equals yt or yb and xl <= x <= xr. Equal bounds give a single horizontal or vertical line.
- R6: draw_sel is 0 for no shape, 1 for circle, 2 for line and 3 for rectangle. When several shapes hit, the rectangle wins over the line and the line wins over the circle. draw is 1 exactly when draw_sel is not 0.
- R7: The parameter and enable inputs are captured only at a rising edge where frame_start=1. A pixel presented at that same edge still uses the previously captured set.
- R8: In the captured enable field shape_en, bit 0 enables the circle, bit 1 the line and bit 2 the rectangle. A disabled shape never hits.
- R9: When draw_valid=0, draw and draw_sel are both 0, whatever the shapes are.
- R10: Coordinates, centres and radii span the full 12-bit range without arithmetic wrap. For example, with centre (0,0) and radius 4095, the far corner (4095,4095) is not on the circle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Captures the parameter inputs into the working set |
| pix_valid | input | 1 | Coordinate on pix_x/pix_y is a visible pixel |
| pix_x | input | 12 | Current pixel column |
| pix_y | input | 12 | Current pixel row |
| shape_en | input | 3 | Enables: bit0 circle, bit1 line, bit2 rectangle |
| circ_cx | input | 12 | Circle centre column |
| circ_cy | input | 12 | Circle centre row |
| circ_r | input | 12 | Circle radius |
| circ_tol | input | 4 | Circle tolerance multiplier of r |
| line_kx | input | 8 | Signed x coefficient |
| line_ky | input | 8 | Signed y coefficient |
| line_c | input | 22 | Signed line constant |
| line_tol | input | 8 | Line tolerance |
| line_xlo | input | 12 | Exclusive lower x limit of the segment |
| line_xhi | input | 12 | Exclusive upper x limit of the segment |
| rect_xl | input | 12 | Rectangle left column |
| rect_xr | input | 12 | Rectangle right column |
| rect_yt | input | 12 | Rectangle top row |
| rect_yb | input | 12 | Rectangle bottom row |
| draw_valid | output | 1 | Result below belongs to a visible pixel |
| draw | output | 1 | Pixel is on a shape |
| draw_sel | output | 2 | Winning shape code |

## Verification
If the valid pipeline gets out of step with the datapath, each shape appears shifted by whole pixels along the scan line. This shows at the ports within three clocks of the first streamed pixel that lands on a stroke. A working parameter set that is reloaded at the wrong time shows the new shape before the next frame start, in the first probe after the inputs change. A wrong priority or a wrong stage register shows as a wrong draw_sel code on pixels where shapes overlap, three cycles after such a pixel. Wrap in the squares shows only at extreme coordinates, so the far corners of the 12-bit range are probed directly.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    parameter int CW     = 12;          // coordinate width
    parameter int KW     = 8;           // line coefficient width
    parameter int CTW    = 4;           // circle tolerance width
    parameter int LTW    = 8;           // line tolerance width
    parameter int NSHAPE = 3;
    localparam int DW    = CW + 1;      // signed coordinate difference
    localparam int LCW   = KW + CW + 2; // line constant width
    localparam int AW    = 2 * CW + 4;  // accumulation width, holds 2*(2^CW)^2

    typedef enum logic [1:0] {
        SH_NONE = 2'd0,
        SH_CIRC = 2'd1,
        SH_LINE = 2'd2,
        SH_RECT = 2'd3
    } shape_e;

    typedef struct packed {
        logic [CW-1:0]  cx;
        logic [CW-1:0]  cy;
        logic [CW-1:0]  r;
        logic [CTW-1:0] tol;
    } circ_prm_t;

    typedef struct packed {
        logic [KW-1:0]  kx;
        logic [KW-1:0]  ky;
        logic [LCW-1:0] c;
        logic [LTW-1:0] tol;
        logic [CW-1:0]  xlo;
        logic [CW-1:0]  xhi;
    } line_prm_t;

    typedef struct packed {
        logic [CW-1:0] xl;
        logic [CW-1:0] xr;
        logic [CW-1:0] yt;
        logic [CW-1:0] yb;
    } rect_prm_t;

    typedef struct packed {
        logic [NSHAPE-1:0] en;
        circ_prm_t         circ;
        line_prm_t         line;
        rect_prm_t         rect;
    } shape_set_t;

    function automatic logic signed [AW-1:0] sabs(input logic signed [AW-1:0] v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic signed [AW-1:0] uext(input logic [CW-1:0] v);
        return $signed({{(AW-CW){1'b0}}, v});
    endfunction
endpackage

// File: rtl/ovl_param_bank.sv
module ovl_param_bank
    import ovl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  shape_set_t nxt,
    output shape_set_t act
);
    always_ff @(posedge clk) begin
        if (rst)       act <= '0;
        else if (load) act <= nxt;
    end
endmodule

// File: rtl/ovl_circle_eval.sv
module ovl_circle_eval
    import ovl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  circ_prm_t     prm,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    output logic          hit
);
    // stage A: offsets from the centre
    logic signed [DW-1:0] dx_a, dy_a;
    logic [CW-1:0]        r_a;
    logic [CTW-1:0]       tol_a;
    logic                 en_a;
    // stage B: squared distance, squared radius, bound
    logic signed [AW-1:0] d2_b, r2_b, bnd_b;
    logic                 en_b;

    logic signed [AW-1:0] dxw, dyw, rw, tw;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_a <= 1'b0;
            en_b <= 1'b0;
        end else begin
            en_a <= en;
            en_b <= en_a;
        end
        dx_a  <= $signed({1'b0, x}) - $signed({1'b0, prm.cx});
        dy_a  <= $signed({1'b0, y}) - $signed({1'b0, prm.cy});
        r_a   <= prm.r;
        tol_a <= prm.tol;
        d2_b  <= dxw * dxw + dyw * dyw;
        r2_b  <= rw * rw;
        bnd_b <= rw * tw;
    end

    always_comb begin
        dxw = AW'(dx_a);
        dyw = AW'(dy_a);
        rw  = uext(r_a);
        tw  = $signed({{(AW-CTW){1'b0}}, tol_a});
    end

    assign hit = en_b && (sabs(d2_b - r2_b) <= bnd_b);
endmodule

// File: rtl/ovl_line_eval.sv
module ovl_line_eval
    import ovl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  line_prm_t     prm,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    output logic          hit
);
    // stage A: the two products, the constant, the segment window
    logic signed [AW-1:0] px_a, py_a, c_a, tol_a;
    logic                 rng_a, en_a;
    // stage B: tolerance decision
    logic                 hit_b;

    logic signed [AW-1:0] kxw, kyw, resid;

    always_comb begin
        kxw   = AW'($signed(prm.kx));
        kyw   = AW'($signed(prm.ky));
        resid = px_a + py_a - c_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_a  <= 1'b0;
            hit_b <= 1'b0;
        end else begin
            en_a  <= en;
            hit_b <= en_a && rng_a && (sabs(resid) <= tol_a);
        end
        px_a  <= kxw * uext(x);
        py_a  <= kyw * uext(y);
        c_a   <= AW'($signed(prm.c));
        tol_a <= $signed({{(AW-LTW){1'b0}}, prm.tol});
        rng_a <= (x > prm.xlo) && (x < prm.xhi);
    end

    assign hit = hit_b;
endmodule

// File: rtl/ovl_rect_eval.sv
module ovl_rect_eval
    import ovl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  rect_prm_t     prm,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    output logic          hit
);
    logic on_col, on_row, hit_a, hit_b;

    always_comb begin
        on_col = ((x == prm.xl) || (x == prm.xr)) && (y >= prm.yt) && (y <= prm.yb);
        on_row = ((y == prm.yt) || (y == prm.yb)) && (x >= prm.xl) && (x <= prm.xr);
    end

    // comparisons resolve in stage A; stage B only aligns with the other shapes
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_a <= 1'b0;
            hit_b <= 1'b0;
        end else begin
            hit_a <= en && (on_col || on_row);
            hit_b <= hit_a;
        end
    end

    assign hit = hit_b;
endmodule

// File: rtl/shape_overlay.sv
module shape_overlay
    import ovl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                pix_valid,
    input  logic [11:0]         pix_x,
    input  logic [11:0]         pix_y,
    input  logic [2:0]          shape_en,
    input  logic [11:0]         circ_cx,
    input  logic [11:0]         circ_cy,
    input  logic [11:0]         circ_r,
    input  logic [3:0]          circ_tol,
    input  logic signed [7:0]   line_kx,
    input  logic signed [7:0]   line_ky,
    input  logic signed [21:0]  line_c,
    input  logic [7:0]          line_tol,
    input  logic [11:0]         line_xlo,
    input  logic [11:0]         line_xhi,
    input  logic [11:0]         rect_xl,
    input  logic [11:0]         rect_xr,
    input  logic [11:0]         rect_yt,
    input  logic [11:0]         rect_yb,
    output logic                draw_valid,
    output logic                draw,
    output logic [1:0]          draw_sel
);
    shape_set_t nxt_set, act_set;
    logic       v_a, v_b;
    logic       circ_hit_b, line_hit_b, rect_hit_b;
    shape_e     win;

    always_comb begin
        nxt_set          = '0;
        nxt_set.en       = shape_en;
        nxt_set.circ.cx  = circ_cx;
        nxt_set.circ.cy  = circ_cy;
        nxt_set.circ.r   = circ_r;
        nxt_set.circ.tol = circ_tol;
        nxt_set.line.kx  = line_kx;
        nxt_set.line.ky  = line_ky;
        nxt_set.line.c   = line_c;
        nxt_set.line.tol = line_tol;
        nxt_set.line.xlo = line_xlo;
        nxt_set.line.xhi = line_xhi;
        nxt_set.rect.xl  = rect_xl;
        nxt_set.rect.xr  = rect_xr;
        nxt_set.rect.yt  = rect_yt;
        nxt_set.rect.yb  = rect_yb;
    end

    ovl_param_bank u_bank (
        .clk (clk), .rst (rst), .load (frame_start), .nxt (nxt_set), .act (act_set)
    );

    ovl_circle_eval u_circ (
        .clk (clk), .rst (rst), .en (act_set.en[0]), .prm (act_set.circ),
        .x (pix_x), .y (pix_y), .hit (circ_hit_b)
    );

    ovl_line_eval u_line (
        .clk (clk), .rst (rst), .en (act_set.en[1]), .prm (act_set.line),
        .x (pix_x), .y (pix_y), .hit (line_hit_b)
    );

    ovl_rect_eval u_rect (
        .clk (clk), .rst (rst), .en (act_set.en[2]), .prm (act_set.rect),
        .x (pix_x), .y (pix_y), .hit (rect_hit_b)
    );

    always_comb begin
        if (!v_b)            win = SH_NONE;
        else if (rect_hit_b) win = SH_RECT;
        else if (line_hit_b) win = SH_LINE;
        else if (circ_hit_b) win = SH_CIRC;
        else                 win = SH_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_a        <= 1'b0;
            v_b        <= 1'b0;
            draw_valid <= 1'b0;
            draw       <= 1'b0;
            draw_sel   <= SH_NONE;
        end else begin
            v_a        <= pix_valid;
            v_b        <= v_a;
            draw_valid <= v_b;
            draw       <= (win != SH_NONE);
            draw_sel   <= win;
        end
    end
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker
    import ovl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frame_start,
    input logic       pix_valid,
    input logic       stage_valid,
    input logic       rect_hit,
    input logic       line_hit,
    input shape_set_t act,
    input logic       draw_valid,
    input logic       draw,
    input logic [1:0] draw_sel
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (draw_valid == $past(pix_valid, 3))); // R2

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !draw_valid |-> (!draw && draw_sel == 2'd0)); // R9

    AST_DRAW_MATCHES_SEL: assert property (@(posedge clk) disable iff (rst)
        draw_valid |-> (draw == (draw_sel != 2'd0))); // R6

    AST_RECT_WINS: assert property (@(posedge clk) disable iff (rst)
        (stage_valid && rect_hit) |=> (draw_sel == 2'd3)); // R6

    AST_LINE_OVER_CIRCLE: assert property (@(posedge clk) disable iff (rst)
        (stage_valid && line_hit && !rect_hit) |=> (draw_sel == 2'd2)); // R6

    AST_SET_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(act)); // R7
endmodule

bind shape_overlay ovl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .stage_valid (v_b),
    .rect_hit    (rect_hit_b),
    .line_hit    (line_hit_b),
    .act         (act_set),
    .draw_valid  (draw_valid),
    .draw        (draw),
    .draw_sel    (draw_sel)
);

// File: tb/tb_shape_overlay.sv
`timescale 1ns/1ps
module tb_shape_overlay;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0, pix_valid = 1'b0;
    logic [11:0] pix_x = '0, pix_y = '0;
    logic [2:0]  shape_en = '0;
    logic [11:0] circ_cx = '0, circ_cy = '0, circ_r = '0;
    logic [3:0]  circ_tol = '0;
    logic signed [7:0]  line_kx = '0, line_ky = '0;
    logic signed [21:0] line_c = '0;
    logic [7:0]  line_tol = '0;
    logic [11:0] line_xlo = '0, line_xhi = '0;
    logic [11:0] rect_xl = '0, rect_xr = '0, rect_yt = '0, rect_yb = '0;
    logic draw_valid, draw;
    logic [1:0] draw_sel;

    int n_chk = 0, n_fail = 0;
    // working copy as the bench believes it was captured
    int a_en = 0, a_cx = 0, a_cy = 0, a_r = 0, a_ct = 0;
    int a_kx = 0, a_ky = 0, a_c = 0, a_lt = 0, a_xlo = 0, a_xhi = 0;
    int a_xl = 0, a_xr = 0, a_yt = 0, a_yb = 0;

    always #2 clk = ~clk;   // 250 MHz

    shape_overlay dut (.*);

    task automatic cmp(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int code(input int v, input int sel);
        return v * 8 + ((sel != 0) ? 4 : 0) + sel;
    endfunction

    function automatic int model(input int x, input int y);
        int d, e;
        bit rh, lh, ch;
        rh = a_en[2] && ((((x == a_xl) || (x == a_xr)) && y >= a_yt && y <= a_yb) ||
                         (((y == a_yt) || (y == a_yb)) && x >= a_xl && x <= a_xr));
        e  = a_kx * x + a_ky * y - a_c;
        lh = a_en[1] && (x > a_xlo) && (x < a_xhi) && ((e < 0 ? -e : e) <= a_lt);
        d  = (x - a_cx) * (x - a_cx) + (y - a_cy) * (y - a_cy) - a_r * a_r;
        ch = a_en[0] && ((d < 0 ? -d : d) <= a_r * a_ct);
        return rh ? 3 : lh ? 2 : ch ? 1 : 0;
    endfunction

    task automatic capture_copy();
        a_en = int'(shape_en); a_cx = int'(circ_cx); a_cy = int'(circ_cy);
        a_r = int'(circ_r); a_ct = int'(circ_tol);
        a_kx = int'(line_kx); a_ky = int'(line_ky); a_c = int'(line_c);
        a_lt = int'(line_tol); a_xlo = int'(line_xlo); a_xhi = int'(line_xhi);
        a_xl = int'(rect_xl); a_xr = int'(rect_xr); a_yt = int'(rect_yt); a_yb = int'(rect_yb);
    endtask

    task automatic load();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        capture_copy();
    endtask

    task automatic probe(input int x, input int y, input int exp_sel, input string req);
        @(negedge clk); pix_x = 12'(x); pix_y = 12'(y); pix_valid = 1'b1;
        @(negedge clk); pix_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cmp(req, code(int'(draw_valid), int'(draw_sel)) + (int'(draw) != (draw_sel != 0) ? 16 : 0),
            code(1, exp_sel));
    endtask

    task automatic set_circle(input int cx, input int cy, input int r, input int t);
        circ_cx = 12'(cx); circ_cy = 12'(cy); circ_r = 12'(r); circ_tol = 4'(t);
    endtask
    task automatic set_line(input int kx, input int ky, input int c, input int t, input int lo, input int hi);
        line_kx = 8'(kx); line_ky = 8'(ky); line_c = 22'(c); line_tol = 8'(t);
        line_xlo = 12'(lo); line_xhi = 12'(hi);
    endtask
    task automatic set_rect(input int xl, input int xr, input int yt, input int yb);
        rect_xl = 12'(xl); rect_xr = 12'(xr); rect_yt = 12'(yt); rect_yb = 12'(yb);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        cmp("R1 outputs in reset", code(int'(draw_valid), int'(draw_sel)) + int'(draw) * 4, 0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1 outputs after reset", code(int'(draw_valid), int'(draw_sel)) + int'(draw) * 4, 0);
        probe(0, 0, 0, "R1 no shape before first load");
    endtask

    task automatic t_circle();
        shape_en = 3'b001; set_circle(100, 80, 20, 1); load();
        probe(120, 80, 1, "R3 circle east point");
        probe(100, 60, 1, "R3 circle north point");
        probe(114, 94, 1, "R3 circle diagonal near radius");
        probe(121, 80, 0, "R3 circle one pixel outside");
        probe(100, 80, 0, "R3 circle centre");
    endtask

    task automatic t_line();
        shape_en = 3'b010; set_line(1, -1, 0, 0, 10, 50); load();
        probe(20, 20, 2, "R4 line on diagonal");
        probe(49, 49, 2, "R4 line just inside upper limit");
        probe(10, 10, 0, "R4 line lower limit is exclusive");
        probe(50, 50, 0, "R4 line upper limit is exclusive");
        probe(20, 21, 0, "R4 line residual 1 over tol 0");
    endtask

    task automatic t_rect();
        shape_en = 3'b100; set_rect(30, 60, 40, 70); load();
        probe(30, 50, 3, "R5 left edge");
        probe(45, 40, 3, "R5 top edge");
        probe(60, 70, 3, "R5 bottom right corner");
        probe(45, 50, 0, "R5 interior not drawn");
        probe(61, 50, 0, "R5 outside right");
        probe(30, 39, 0, "R5 above top");
        set_rect(33, 33, 0, 4095); load();
        probe(33, 1000, 3, "R5 vertical line");
        probe(34, 1000, 0, "R5 vertical line neighbour");
    endtask

    task automatic setup_overlap(input int en);
        shape_en = 3'(en);
        set_rect(10, 50, 10, 50);
        set_line(1, -1, 0, 0, 0, 100);
        set_circle(30, 30, 20, 1);
        load();
    endtask

    task automatic t_priority();
        setup_overlap(7);
        probe(10, 10, 3, "R6 rect beats line");
        probe(44, 44, 2, "R6 line beats circle");
        probe(16, 44, 1, "R6 circle alone");
        probe(70, 5, 0, "R6 no shape code 0");
    endtask

    task automatic t_enable();
        setup_overlap(3);
        probe(10, 10, 2, "R8 rect disabled exposes line");
        setup_overlap(1);
        probe(44, 44, 1, "R8 line disabled exposes circle");
        setup_overlap(0);
        probe(44, 44, 0, "R8 all disabled");
    endtask

    task automatic t_stream();
        int exp_q[0:1023];
        int n;
        shape_en = 3'b111;
        set_circle(16, 16, 10, 2);
        set_line(2, -3, -5, 2, 3, 28);
        set_rect(4, 27, 6, 25);
        load();
        n = 0;
        for (int i = 0; i < 32 * 32 + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                cmp("R2/R3/R4/R5 streamed pixel", code(int'(draw_valid), int'(draw_sel)),
                    exp_q[i - 3]);
                if (!draw_valid) cmp("R9 gap quiet", int'(draw), 0);
            end
            if (i < 32 * 32) begin
                pix_x = 12'(i % 32); pix_y = 12'(i / 32);
                pix_valid = (i % 7) != 6;
                exp_q[i] = pix_valid ? code(1, model(i % 32, i / 32)) : 0;
                if (pix_valid && model(i % 32, i / 32) != 0) n++;
            end else begin
                pix_valid = 1'b0;
            end
        end
        cmp("R2 stream exercised hits", int'(n > 50), 1);
    endtask

    task automatic t_double_buffer();
        shape_en = 3'b001; set_circle(100, 80, 20, 1); load();
        shape_en = 3'b100; set_rect(200, 210, 200, 210);
        probe(200, 200, 0, "R7 pending rect ignored");
        probe(120, 80, 1, "R7 old circle still active");
        @(negedge clk);
        pix_x = 12'd120; pix_y = 12'd80; pix_valid = 1'b1; frame_start = 1'b1;
        @(negedge clk); pix_valid = 1'b0; frame_start = 1'b0;
        @(negedge clk); @(negedge clk);
        cmp("R7 pixel at load edge uses old set", code(int'(draw_valid), int'(draw_sel)), code(1, 1));
        capture_copy();
        probe(200, 200, 3, "R7 new rect after load");
        probe(120, 80, 0, "R7 old circle gone after load");
    endtask

    task automatic t_extremes();
        shape_en = 3'b011;
        set_circle(0, 0, 4095, 15);
        set_line(127, 127, 127 * 8189, 0, 0, 4095);
        load();
        probe(4095, 0, 1, "R10 circle far east");
        probe(0, 4095, 1, "R10 circle far south");
        probe(4095, 4095, 0, "R10 far corner off circle");
        probe(4094, 4095, 2, "R10 large line product");
        probe(4095, 4094, 0, "R10 line upper limit exclusive");
    endtask

    task automatic t_idle_output();
        @(negedge clk);
        cmp("R9 idle outputs", code(int'(draw_valid), int'(draw_sel)) + int'(draw) * 4, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_circle();
        t_line();
        t_rect();
        t_priority();
        t_enable();
        t_stream();
        t_double_buffer();
        t_extremes();
        t_idle_output();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule